// File: doc/BRIEF.md
# Spread-Spectrum Profile Selector and Triangle Modulator

This block picks the active spread-spectrum profile for a clock synthesizer and turns it into a signed frequency-offset word, one word per reference cycle. A fractional feedback divider uses that word to sweep the output frequency along a symmetric triangle. The profile comes from a 4-bit spread code, a 2-bit charge-pump step and a spread-enable bit. The code is taken either from three select pins or from a software register, depending on a mode bit. The code's top bit chooses one of two shapes. Down-spread sweeps from nominal down to minus the selected amount. Center-spread sweeps symmetrically about nominal.

The offset word counts in steps of 0.005 % of the nominal frequency. Each selectable amount is stored as an integer number of hundredths of a percent, which equals half the amount in word units. A new profile is adopted only when the triangle phase returns to zero. A change of setting therefore never cuts a sweep short and never produces a step outside the nominal limits. The modulation period is 2^(QTR_LOG2+2) reference cycles.

Top module: `ssm_modulator`

## Requirements
- R1: After reset, mod_word is 0 and center_mode is 0. The active profile is spread enabled, code 0, charge-pump step 00.
- R2: When sw_mode is 0, the code is {hw_sel[2:0], 0}. reg_code has no effect on the output.
- R3: When sw_mode is 1, the code is reg_code[3:0].
- R4: Let A be the table amount in hundredths of a percent. If code bit 3 is 0 (down), mod_word sweeps from 0 to -2A and back. If code bit 3 is 1 (center), it sweeps over +A to -A. Values are truncated toward zero.
- R5: With charge-pump step 00, the amounts in hundredths for codes 0 to 7 are 65, 80, 90, 110, 130, 140, 180, 225. For codes 8 to 15 they are 25, 30, 40, 45, 60, 80, 100, 110.
- R6: With step 11, codes 0 to 7 give 80, 90, 120, 140, 160, 175, 220, 260. Codes 8 to 15 give 38, 40, 50, 60, 75, 100, 115, 130.
- R7: With step 01, codes 0 to 7 give 90, 110, 140, 160, 200, 220, 275, 330. Codes 8 to 15 give 40, 50, 60, 70, 90, 125, 145, 165. Step 10 uses the step-00 table.
- R8: While the active profile has spread disabled, mod_word is 0 in every cycle.
- R9: The phase counts 0 to 4Q-1 and then wraps, with Q = 2^QTR_LOG2. The pin and register settings are latched only in the cycle where the phase is 0. mod_word shows the offset for the phase one cycle after that phase, and it is 0 after phase 0. The offset for phase p is as follows. Down: -(2A*u)/(2Q), where u = p for p <= 2Q and u = 4Q-p otherwise. Center: A*t/Q, where t = p for p <= Q, t = 2Q-p for p <= 3Q, and t = p-4Q otherwise.
- R10: center_mode equals bit 3 of the active code, whether spread is enabled or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hw_sel | input | 3 | Select pins, code bits 3..1 in hardware mode |
| reg_code | input | 4 | Software spread code |
| sw_mode | input | 1 | 1 = code from register, 0 = code from pins |
| spread_en | input | 1 | Spread enable |
| cp_step | input | 2 | Charge-pump step selecting the amount table |
| mod_word | output | WORD_W | Signed offset, units of 0.005 % |
| center_mode | output | 1 | 1 = center-spread profile active |

## Verification
The bench builds the block with QTR_LOG2 = 2, which gives a 16-cycle modulation period. At that length, every profile can be latched, swept through both peaks and compared within a few dozen cycles. The short period also lets the bench change settings mid-sweep many times, so the boundary-only adoption is exercised well. Even with so few phase steps, the truncation in the intermediate offset values shows up for small amounts such as 38 hundredths. The peak values checked cover the largest amount (-660) and the narrowest center profile.

// File: rtl/ssm_pkg.sv
// Shared types and the spread-amount lookup for the spread modulator.
// Assumes amounts are held in hundredths of a percent (max 330).
package ssm_pkg;

    localparam int HUND_W = 9;

    typedef struct packed {
        logic       en;
        logic [1:0] cp;
        logic [3:0] code;
    } spread_cfg_t;

    // Amount in hundredths of a percent for a charge-pump step and a code.
    // Step 10 is not a defined setting and falls back to the 00 table.
    function automatic logic [HUND_W-1:0] spread_hundredths(input logic [1:0] cp,
                                                            input logic [3:0] code);
        logic [HUND_W-1:0] v;
        case (cp)
            2'b11: begin
                case (code)
                    4'd0: v = 9'd80;   4'd1: v = 9'd90;   4'd2: v = 9'd120;  4'd3: v = 9'd140;
                    4'd4: v = 9'd160;  4'd5: v = 9'd175;  4'd6: v = 9'd220;  4'd7: v = 9'd260;
                    4'd8: v = 9'd38;   4'd9: v = 9'd40;   4'd10: v = 9'd50;  4'd11: v = 9'd60;
                    4'd12: v = 9'd75;  4'd13: v = 9'd100; 4'd14: v = 9'd115; default: v = 9'd130;
                endcase
            end
            2'b01: begin
                case (code)
                    4'd0: v = 9'd90;   4'd1: v = 9'd110;  4'd2: v = 9'd140;  4'd3: v = 9'd160;
                    4'd4: v = 9'd200;  4'd5: v = 9'd220;  4'd6: v = 9'd275;  4'd7: v = 9'd330;
                    4'd8: v = 9'd40;   4'd9: v = 9'd50;   4'd10: v = 9'd60;  4'd11: v = 9'd70;
                    4'd12: v = 9'd90;  4'd13: v = 9'd125; 4'd14: v = 9'd145; default: v = 9'd165;
                endcase
            end
            default: begin
                case (code)
                    4'd0: v = 9'd65;   4'd1: v = 9'd80;   4'd2: v = 9'd90;   4'd3: v = 9'd110;
                    4'd4: v = 9'd130;  4'd5: v = 9'd140;  4'd6: v = 9'd180;  4'd7: v = 9'd225;
                    4'd8: v = 9'd25;   4'd9: v = 9'd30;   4'd10: v = 9'd40;  4'd11: v = 9'd45;
                    4'd12: v = 9'd60;  4'd13: v = 9'd80;  4'd14: v = 9'd100; default: v = 9'd110;
                endcase
            end
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ssm_phase_gen.sv
// Free-running triangle phase counter. One modulation period is 2^PH_W
// cycles. boundary flags phase zero, where the offset is zero.
module ssm_phase_gen #(
    parameter int PH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            boundary
);

    // Advance the phase once per reference cycle and wrap at the period.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + 1'b1;
    end

    assign boundary = (phase == '0);

endmodule

// File: rtl/ssm_cfg_sel.sv
// Chooses the pin or register code source and holds the active profile.
// Assumes settings may change at any time. They are adopted only at boundary.
module ssm_cfg_sel
    import ssm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  hw_sel,
    input  logic [3:0]  reg_code,
    input  logic        sw_mode,
    input  logic        spread_en,
    input  logic [1:0]  cp_step,
    input  logic        boundary,
    output spread_cfg_t active
);

    spread_cfg_t pending;

    // Pick the code source. Hardware mode forces the low code bit to zero.
    always_comb begin
        pending.en   = spread_en;
        pending.cp   = cp_step;
        pending.code = sw_mode ? reg_code : {hw_sel, 1'b0};
    end

    // Adopt the pending profile only at the zero-offset phase.
    always_ff @(posedge clk) begin
        if (!rst_n)        active <= '{en: 1'b1, cp: 2'b00, code: 4'd0};
        else if (boundary) active <= pending;
    end

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(active));

endmodule

// File: rtl/ssm_shaper.sv
// Maps the phase and the active amount to the next signed offset word.
// Assumes phase spans 4*Q cycles with Q = 2^QTR_LOG2, and amounts are in hundredths.
module ssm_shaper
    import ssm_pkg::*;
#(
    parameter int QTR_LOG2 = 6,
    parameter int WORD_W   = 12
) (
    input  logic [QTR_LOG2+1:0]      phase,
    input  logic [HUND_W-1:0]        hund,
    input  logic                     center,
    input  logic                     en,
    output logic signed [WORD_W-1:0] word_next
);

    localparam int PH_W   = QTR_LOG2 + 2;
    localparam int PROD_W = HUND_W + PH_W + 1;
    localparam logic [PH_W:0] Q_X    = (PH_W+1)'(1 << QTR_LOG2);
    localparam logic [PH_W:0] TWO_Q  = (PH_W+1)'(2 << QTR_LOG2);
    localparam logic [PH_W:0] FOUR_Q = (PH_W+1)'(4 << QTR_LOG2);

    logic [PH_W:0]     phase_x, fold, tri_mag, sel;
    logic [PROD_W-1:0] prod;
    logic [WORD_W-1:0] mag;
    logic              neg;

    // Fold the phase into ramp distances for the down and center shapes.
    always_comb begin
        phase_x = {1'b0, phase};
        fold    = (phase_x <= TWO_Q) ? phase_x : (FOUR_Q - phase_x);
        tri_mag = (fold <= Q_X) ? fold : (TWO_Q - fold);
        sel     = center ? tri_mag : fold;
        prod    = PROD_W'(hund) * PROD_W'(sel);
        mag     = WORD_W'(prod >> QTR_LOG2);
        neg     = !center || (phase_x > TWO_Q);
    end

    // Apply the sign and force zero offset when spread is off.
    always_comb begin
        if (!en)      word_next = '0;
        else if (neg) word_next = -$signed(mag);
        else          word_next = $signed(mag);
    end

endmodule

// File: rtl/ssm_modulator.sv
// Spread-spectrum profile selector and triangle modulator (top).
// Produces one offset word per reference cycle in 0.005 % units.
// Assumes WORD_W >= 11 so that the largest swing (-660) fits.
module ssm_modulator
    import ssm_pkg::*;
#(
    parameter int QTR_LOG2 = 6,
    parameter int WORD_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        hw_sel,
    input  logic [3:0]        reg_code,
    input  logic              sw_mode,
    input  logic              spread_en,
    input  logic [1:0]        cp_step,
    output logic [WORD_W-1:0] mod_word,
    output logic              center_mode
);

    localparam int PH_W = QTR_LOG2 + 2;

    logic [PH_W-1:0]          phase;
    logic                     boundary;
    spread_cfg_t              active;
    logic [HUND_W-1:0]        hund;
    logic signed [WORD_W-1:0] word_next;
    logic signed [WORD_W-1:0] hund_lim;

    ssm_phase_gen #(.PH_W(PH_W)) i_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .boundary (boundary)
    );

    ssm_cfg_sel i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_sel    (hw_sel),
        .reg_code  (reg_code),
        .sw_mode   (sw_mode),
        .spread_en (spread_en),
        .cp_step   (cp_step),
        .boundary  (boundary),
        .active    (active)
    );

    assign hund     = spread_hundredths(active.cp, active.code);
    assign hund_lim = $signed(WORD_W'(hund));

    ssm_shaper #(.QTR_LOG2(QTR_LOG2), .WORD_W(WORD_W)) i_shape (
        .phase     (phase),
        .hund      (hund),
        .center    (active.code[3]),
        .en        (active.en),
        .word_next (word_next)
    );

    // Register the offset word for a glitch-free divider input.
    always_ff @(posedge clk) begin
        if (!rst_n) mod_word <= '0;
        else        mod_word <= word_next;
    end

    assign center_mode = active.code[3];

    assert_zero_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !active.en |=> (mod_word == '0));

    assert_down_nonpos_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active.en && !active.code[3]) |=> ($signed(mod_word) <= 0));

    assert_center_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active.en && active.code[3]) |=>
            (($signed(mod_word) <= $past(hund_lim)) && ($signed(mod_word) >= -$past(hund_lim))));

    assert_zero_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (mod_word == '0));

endmodule

// File: tb/test_ssm_modulator.sv
module test_ssm_modulator;

    localparam int CLK_PERIOD = 10;
    localparam int QL     = 2;
    localparam int Q      = 1 << QL;
    localparam int PERIOD = 4 * Q;
    localparam int WORD_W = 12;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [2:0]        hw_sel;
    logic [3:0]        reg_code;
    logic              sw_mode;
    logic              spread_en;
    logic [1:0]        cp_step;
    logic [WORD_W-1:0] mod_word;
    logic              center_mode;

    ssm_modulator #(.QTR_LOG2(QL), .WORD_W(WORD_W)) i_ssm_modulator (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_sel      (hw_sel),
        .reg_code    (reg_code),
        .sw_mode     (sw_mode),
        .spread_en   (spread_en),
        .cp_step     (cp_step),
        .mod_word    (mod_word),
        .center_mode (center_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tab00[16] = '{65, 80, 90, 110, 130, 140, 180, 225, 25, 30, 40, 45, 60, 80, 100, 110};
    int tab11[16] = '{80, 90, 120, 140, 160, 175, 220, 260, 38, 40, 50, 60, 75, 100, 115, 130};
    int tab01[16] = '{90, 110, 140, 160, 200, 220, 275, 330, 40, 50, 60, 70, 90, 125, 145, 165};

    typedef struct {
        int    word;
        bit    flag;
        string tag;
    } exp_t;

    exp_t  sbq[$];
    string cur_req = "R1";
    int    checks = 0;
    int    failures = 0;
    int    ph, m_cp, m_code;
    bit    m_en;
    int    stat_min, stat_max;
    bit    done = 0;

    function automatic int ref_amt(int cp, int code);
        if (cp == 3) return tab11[code];
        if (cp == 1) return tab01[code];
        return tab00[code];
    endfunction

    function automatic int ref_word(int p, bit en, int cp, int code);
        int h, t, u;
        if (!en) return 0;
        h = ref_amt(cp, code);
        if (code >= 8) begin
            if (p <= Q)          t = p;
            else if (p <= 3 * Q) t = 2 * Q - p;
            else                 t = p - 4 * Q;
            return (h * t) / Q;
        end
        u = (p <= 2 * Q) ? p : 4 * Q - p;
        return -((2 * h * u) / (2 * Q));
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model: pushes the expected outputs of each clock edge.
    always @(posedge clk) begin
        exp_t e;
        if (!rst_n) begin
            ph = 0; m_en = 1'b1; m_cp = 0; m_code = 0;
            e.word = 0;
        end else begin
            e.word = ref_word(ph, m_en, m_cp, m_code);
            if (ph == 0) begin
                m_en   = spread_en;
                m_cp   = int'(cp_step);
                m_code = sw_mode ? int'(reg_code) : int'(hw_sel) * 2;
            end
            ph = (ph + 1) % PERIOD;
        end
        e.flag = (m_code >= 8);
        e.tag  = cur_req;
        sbq.push_back(e);
    end

    // Monitor: pops the expected outputs and compares them away from the edge.
    always @(negedge clk) begin
        exp_t e;
        int   act;
        if (sbq.size() > 0) begin
            e   = sbq.pop_front();
            act = int'($signed(mod_word));
            checks++;
            if (mod_word !== WORD_W'(e.word)) begin
                failures++;
                $display("FAIL %s mod_word actual=%0d expected=%0d", e.tag, act, e.word);
            end
            checks++;
            if (center_mode !== e.flag) begin
                failures++;
                $display("FAIL R10 center_mode actual=%0b expected=%0b", center_mode, e.flag);
            end
            if (act < stat_min) stat_min = act;
            if (act > stat_max) stat_max = act;
        end
    end

    task automatic setcfg(bit sw, logic [2:0] pins, logic [3:0] code, bit en,
                          logic [1:0] cp, string req);
        @(negedge clk);
        sw_mode = sw; hw_sel = pins; reg_code = code; spread_en = en; cp_step = cp;
        cur_req = req;
    endtask

    // Let the new profile settle, then record one full period and check its peaks.
    task automatic peak(string req, int lo, int hi, bit flag);
        repeat (2 * PERIOD) @(negedge clk);
        #1;
        stat_min = 99999; stat_max = -99999;
        repeat (PERIOD) @(negedge clk);
        #1;
        chk({req, " min"}, stat_min, lo);
        chk({req, " max"}, stat_max, hi);
        chk("R10 flag", int'(center_mode), int'(flag));
    endtask

    initial begin
        rst_n = 1'b0; sw_mode = 1'b0; hw_sel = 3'b000; reg_code = 4'd0;
        spread_en = 1'b1; cp_step = 2'b00;
        repeat (3) @(negedge clk);
        chk("R1 reset word", int'($signed(mod_word)), 0);
        chk("R1 reset flag", int'(center_mode), 0);
        rst_n = 1'b1;
        peak("R1", -130, 0, 1'b0);
        // R2: pins 111 give code 14; the register's S0 bit is ignored
        setcfg(1'b0, 3'b111, 4'b0001, 1'b1, 2'b00, "R2");
        peak("R2", -100, 100, 1'b1);
        setcfg(1'b1, 3'b000, 4'b1111, 1'b1, 2'b00, "R3");
        peak("R3", -110, 110, 1'b1);
        setcfg(1'b1, 3'b000, 4'b0111, 1'b1, 2'b00, "R5");
        peak("R5", -450, 0, 1'b0);
        setcfg(1'b1, 3'b000, 4'b1000, 1'b1, 2'b11, "R6");
        peak("R6", -38, 38, 1'b1);
        setcfg(1'b1, 3'b000, 4'b0000, 1'b1, 2'b11, "R6");
        peak("R6", -160, 0, 1'b0);
        setcfg(1'b1, 3'b000, 4'b0111, 1'b1, 2'b01, "R7");
        peak("R7", -660, 0, 1'b0);
        setcfg(1'b1, 3'b000, 4'b1000, 1'b1, 2'b10, "R7");
        peak("R7", -25, 25, 1'b1);
        setcfg(1'b1, 3'b000, 4'b1101, 1'b0, 2'b01, "R8");
        peak("R8", 0, 0, 1'b1);
        setcfg(1'b1, 3'b000, 4'b1101, 1'b1, 2'b01, "R4");
        peak("R4", -125, 125, 1'b1);
        setcfg(1'b1, 3'b000, 4'b0011, 1'b1, 2'b01, "R4");
        peak("R4", -320, 0, 1'b0);
        // R9: change mid-sweep; the scoreboard checks that the old sweep finishes
        cur_req = "R9";
        do @(negedge clk); while (ph != 5);
        sw_mode = 1'b1; reg_code = 4'b1111; cp_step = 2'b01; spread_en = 1'b1;
        @(negedge clk); #1;
        chk("R9 old profile kept", int'(center_mode), 0);
        peak("R9", -165, 165, 1'b1);
        do @(negedge clk); while (ph != 9);
        reg_code = 4'b0110;
        peak("R9", -550, 0, 1'b0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule